// File: doc/BRIEF.md
# Prescaled Timer with Alarm and Interrupt Latch

This block keeps a free-running count that advances once every `PRESCALE` core clocks (128 by default). It also holds an alarm compare value and a small interrupt controller. When the count steps onto the alarm value, the alarm interrupt bit is latched. Two external button inputs pass through synchronisers and rising-edge detectors, and each one latches its own interrupt bit. Software reads the latched bits, clears them by writing ones, and chooses through an enable register which latched bits drive the single combined interrupt line.

Software reaches the block through a simple register port. A write happens in any cycle where `bus_wr_i` is high. Reads are combinational from `bus_addr_i`. The byte offsets are timer 0x10, alarm 0x14, latched status 0x38 and enable 0x3C. Every other offset reads zero, and a write to any other offset has no effect.

Top module: `tick_alarm_irq`

## Requirements
- R1: After a synchronous active-low reset, the timer, alarm, status and enable registers read zero and `irq_o` is low.
- R2: The timer advances by exactly one every `PRESCALE` clocks. It wraps from 0xFFFFFFFF to 0.
- R3: A write to the timer loads the written value and restarts the prescaler. The next increment comes exactly `PRESCALE` clocks after the write.
- R4: Status bit 0 is set on the clock where the timer steps onto the alarm value. This includes a wrap onto an alarm of 0. The bit is set only once while the timer stays equal to the alarm. Loading the timer directly with the alarm value does not set it.
- R5: A rising edge on `btn_reset_i` sets status bit 17 (mask 0x20000) on the third clock after the input rises, and only once per press. Holding the button high does not set the bit again after it is cleared.
- R6: A rising edge on `btn_power_i` sets status bit 11 (mask 0x800), with the same timing and once-per-press behaviour as R5.
- R7: A write to the status register clears every bit where the written data is one and leaves every bit where it is zero.
- R8: When a source sets a status bit in the same clock as a write of one clears it, the bit ends up set.
- R9: `irq_o` is high exactly when some bit is one in both the status and the enable register. The enable register has no effect on the status read value.
- R10: Status bits other than 0, 11 and 17 always read zero. Offsets other than the four listed read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register byte offset |
| bus_wdata_i | input | DATA_W | Register write data |
| bus_rdata_o | output | DATA_W | Read data for `bus_addr_i` |
| btn_reset_i | input | 1 | Asynchronous reset-button level |
| btn_power_i | input | 1 | Asynchronous power-button level |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with `PRESCALE` = 8 and keeps the two-stage synchroniser and 32-bit data path. The short prescale puts many timer ticks inside a brief run. That brings within reach the clear-while-equal window of the alarm, the reload-equal case and the wrap from all ones onto an alarm of zero. It also lets the bench place a write-one-to-clear on exactly the clock where a button edge lands.

// File: rtl/tai_pkg.sv
// Package: shared register offsets, interrupt bit positions and the
// register-select type of the prescaled timer / interrupt block.
// Assumes byte offsets that fit in the port address width.
package tai_pkg;

    localparam int OFS_TIMER  = 'h10;
    localparam int OFS_ALARM  = 'h14;
    localparam int OFS_STATUS = 'h38;
    localparam int OFS_ENABLE = 'h3C;

    localparam int BIT_ALARM  = 0;
    localparam int BIT_POWER  = 11;
    localparam int BIT_RESET  = 17;

    localparam int NUM_BTN    = 2;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_TIMER,
        SEL_ALARM,
        SEL_STATUS,
        SEL_ENABLE
    } reg_sel_e;

    // Interrupt bit position for button index i (0 = reset, 1 = power).
    function automatic int btn_bit(input int i);
        return (i == 0) ? BIT_RESET : BIT_POWER;
    endfunction

endpackage

// File: rtl/tai_prescaled_timer.sv
// Module: prescaler plus free-running count.
// The count advances once every PRESCALE clocks. A load writes the count
// and restarts the prescaler. tick_o marks the clock edge where the count
// will increment. Assumes PRESCALE >= 2.
module tai_prescaled_timer #(
    parameter int DATA_W   = 32,
    parameter int PRESCALE = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_val_i,
    output logic [DATA_W-1:0] count_o,
    output logic              tick_o
);
    localparam int PRE_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

    logic [PRE_W-1:0]  pre_q;
    logic [DATA_W-1:0] count_q;

    // Tick when the prescaler is at its last state and no load overrides it.
    always_comb begin
        tick_o = (pre_q == PRE_LAST) && !load_i;
    end

    // Prescaler divider: restart on load or on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (load_i || (pre_q == PRE_LAST)) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    // Count register: load wins over tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load_i) begin
            count_q <= load_val_i;
        end else if (tick_o) begin
            count_q <= count_q + DATA_W'(1);
        end
    end

    assign count_o = count_q;

endmodule

// File: rtl/tai_alarm_match.sv
// Module: alarm compare register and step-onto-match detector.
// hit_o pulses only on a tick whose next count equals the alarm, so a
// direct load or a count that stays equal never fires it again.
// Assumes tick_i is a one-clock pulse from the timer.
module tai_alarm_match #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              tick_i,
    input  logic [DATA_W-1:0] count_i,
    output logic [DATA_W-1:0] alarm_o,
    output logic              hit_o
);
    logic [DATA_W-1:0] alarm_q;
    logic [DATA_W-1:0] next_count;

    // Value the count takes after this tick (wraps naturally).
    always_comb begin
        next_count = count_i + DATA_W'(1);
        hit_o      = tick_i && (next_count == alarm_q);
    end

    // Alarm compare register, written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q <= '0;
        end else if (wr_i) begin
            alarm_q <= wdata_i;
        end
    end

    assign alarm_o = alarm_q;

endmodule

// File: rtl/tai_edge_sync.sv
// Module: synchroniser chain and rising-edge detector for one
// asynchronous level. rise_o is high for one clock per low-to-high
// transition. Assumes STAGES >= 2.
module tai_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the level through the synchroniser and keep the last sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_i};
            prev_q <= sync_q[STAGES-1];
        end
    end

    // Edge: synchronised level high now, low one clock ago.
    always_comb begin
        rise_o = sync_q[STAGES-1] && !prev_q;
    end

endmodule

// File: rtl/tai_irq_regs.sv
// Module: write-one-to-clear status latch, enable mask and combined
// request. A set from a source in the same clock as a clear wins.
// Assumes set_i carries one-clock event pulses.
module tai_irq_regs #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_i,
    input  logic              clr_wr_i,
    input  logic              en_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] status_o,
    output logic [DATA_W-1:0] enable_o,
    output logic              irq_o
);
    logic [DATA_W-1:0] status_q;
    logic [DATA_W-1:0] enable_q;
    logic [DATA_W-1:0] clr_mask;

    // Clear mask is the written data on a status write, otherwise empty.
    always_comb begin
        clr_mask = clr_wr_i ? wdata_i : '0;
    end

    // Status latch: clear first, then OR in new events so sets win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_mask) | set_i;
        end
    end

    // Enable mask register, written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
        end else if (en_wr_i) begin
            enable_q <= wdata_i;
        end
    end

    // Combined request: any latched and enabled bit.
    always_comb begin
        irq_o = |(status_q & enable_q);
    end

    assign status_o = status_q;
    assign enable_o = enable_q;

endmodule

// File: rtl/tick_alarm_irq.sv
// Module: top of the prescaled timer, alarm and interrupt latch.
// Decodes the register port, routes the alarm hit and the button edges
// into fixed status bits, and muxes the read data. Assumes the register
// offsets in tai_pkg fit in ADDR_W bits and the bit positions in DATA_W.
module tick_alarm_irq #(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 8,
    parameter int PRESCALE    = 128,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic              btn_reset_i,
    input  logic              btn_power_i,
    output logic              irq_o
);
    import tai_pkg::*;

    localparam logic [ADDR_W-1:0] A_TIMER  = ADDR_W'(OFS_TIMER);
    localparam logic [ADDR_W-1:0] A_ALARM  = ADDR_W'(OFS_ALARM);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFS_ENABLE);

    reg_sel_e          sel;
    logic              timer_load;
    logic              alarm_wr;
    logic              clr_wr;
    logic              en_wr;
    logic [DATA_W-1:0] timer_val;
    logic [DATA_W-1:0] alarm_val;
    logic [DATA_W-1:0] status_val;
    logic [DATA_W-1:0] enable_val;
    logic              tick;
    logic              alarm_hit;
    logic [NUM_BTN-1:0] btn_level;
    logic [NUM_BTN-1:0] btn_rise;
    logic [DATA_W-1:0] set_vec;

    // Address decode into a register select.
    always_comb begin
        unique case (bus_addr_i)
            A_TIMER:  sel = SEL_TIMER;
            A_ALARM:  sel = SEL_ALARM;
            A_STATUS: sel = SEL_STATUS;
            A_ENABLE: sel = SEL_ENABLE;
            default:  sel = SEL_NONE;
        endcase
    end

    // Per-register write strobes.
    always_comb begin
        timer_load = bus_wr_i && (sel == SEL_TIMER);
        alarm_wr   = bus_wr_i && (sel == SEL_ALARM);
        clr_wr     = bus_wr_i && (sel == SEL_STATUS);
        en_wr      = bus_wr_i && (sel == SEL_ENABLE);
    end

    tai_prescaled_timer #(
        .DATA_W   (DATA_W),
        .PRESCALE (PRESCALE)
    ) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (timer_load),
        .load_val_i (bus_wdata_i),
        .count_o    (timer_val),
        .tick_o     (tick)
    );

    tai_alarm_match #(
        .DATA_W (DATA_W)
    ) alarm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (alarm_wr),
        .wdata_i (bus_wdata_i),
        .tick_i  (tick),
        .count_i (timer_val),
        .alarm_o (alarm_val),
        .hit_o   (alarm_hit)
    );

    assign btn_level = {btn_power_i, btn_reset_i};

    // One synchroniser and edge detector per button input.
    for (genvar g = 0; g < NUM_BTN; g++) begin : g_btn
        tai_edge_sync #(
            .STAGES (SYNC_STAGES)
        ) sync_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (btn_level[g]),
            .rise_o  (btn_rise[g])
        );
    end

    // Route event pulses onto their fixed status bit positions.
    always_comb begin
        set_vec = '0;
        set_vec[BIT_ALARM] = alarm_hit;
        for (int i = 0; i < NUM_BTN; i++) begin
            set_vec[btn_bit(i)] = set_vec[btn_bit(i)] | btn_rise[i];
        end
    end

    tai_irq_regs #(
        .DATA_W (DATA_W)
    ) irq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_vec),
        .clr_wr_i (clr_wr),
        .en_wr_i  (en_wr),
        .wdata_i  (bus_wdata_i),
        .status_o (status_val),
        .enable_o (enable_val),
        .irq_o    (irq_o)
    );

    // Read data mux; unmapped offsets read zero.
    always_comb begin
        unique case (sel)
            SEL_TIMER:  bus_rdata_o = timer_val;
            SEL_ALARM:  bus_rdata_o = alarm_val;
            SEL_STATUS: bus_rdata_o = status_val;
            SEL_ENABLE: bus_rdata_o = enable_val;
            default:    bus_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/tai_checker.sv
// Checker: temporal properties of the timer / interrupt block, bound to
// the top module. Observes the timer count, tick, alarm hit, button edges
// and the status and enable registers.
module tai_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_o,
    input logic [DATA_W-1:0] timer_val,
    input logic              tick,
    input logic              timer_load,
    input logic              alarm_hit,
    input logic [1:0]        btn_rise,
    input logic [DATA_W-1:0] set_vec,
    input logic [DATA_W-1:0] status_val,
    input logic [DATA_W-1:0] enable_val,
    input logic              clr_wr,
    input logic [DATA_W-1:0] bus_wdata_i
);
    localparam logic [DATA_W-1:0] SRC_MASK =
        (DATA_W'(1) << tai_pkg::BIT_ALARM) |
        (DATA_W'(1) << tai_pkg::BIT_POWER) |
        (DATA_W'(1) << tai_pkg::BIT_RESET);

    // R1: the clock after reset, nothing is latched, enabled or requested.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (status_val == '0) && (enable_val == '0) && !irq_o);

    // R2: a tick advances the count by exactly one.
    p_tick_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> timer_val == $past(timer_val) + DATA_W'(1));

    // R2: without tick or load the count holds.
    p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !timer_load) |=> $stable(timer_val));

    // R4: the alarm hit lasts one clock only.
    p_alarm_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |=> !alarm_hit);

    // R5: a reset-button edge pulse lasts one clock only.
    p_reset_btn_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        btn_rise[0] |=> !btn_rise[0]);

    // R6: a power-button edge pulse lasts one clock only.
    p_power_btn_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        btn_rise[1] |=> !btn_rise[1]);

    // R7: bits written with one and not set this clock are clear afterwards.
    p_w1c_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> (status_val & $past(bus_wdata_i & ~set_vec)) == '0);

    // R8: every event pulse shows up in status on the next clock.
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> (status_val & $past(set_vec)) == $past(set_vec));

    // R10: only source bit positions can ever be latched.
    p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (status_val & ~SRC_MASK) == '0);

endmodule

bind tick_alarm_irq tai_checker #(
    .DATA_W (DATA_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_o       (irq_o),
    .timer_val   (timer_val),
    .tick        (tick),
    .timer_load  (timer_load),
    .alarm_hit   (alarm_hit),
    .btn_rise    (btn_rise),
    .set_vec     (set_vec),
    .status_val  (status_val),
    .enable_val  (enable_val),
    .clr_wr      (clr_wr),
    .bus_wdata_i (bus_wdata_i)
);

// File: tb/tick_alarm_irq_tb_top.sv
// Bench: a behavioural reference model updated on every rising edge and
// compared against the read port and irq_o 5 ns later. Directed scenarios
// add named checks for each requirement.
module tick_alarm_irq_tb_top;
    localparam int P  = 8;
    localparam int DW = 32;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          btn_r = 1'b0;
    logic          btn_p = 1'b0;
    logic [DW-1:0] rdata;
    logic          irq;

    always #10 clk = ~clk;

    tick_alarm_irq #(
        .DATA_W      (DW),
        .ADDR_W      (AW),
        .PRESCALE    (P),
        .SYNC_STAGES (2)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .btn_reset_i (btn_r),
        .btn_power_i (btn_p),
        .irq_o       (irq)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    string tag = "R1";

    // Reference model state.
    int          m_pre = 0;
    logic [31:0] m_timer = '0, m_alarm = '0, m_stat = '0, m_en = '0;
    logic [2:0]  m_r = '0, m_p = '0;

    // Model update on each rising edge from the inputs held since the falling edge.
    always @(posedge clk) begin : model
        logic        tk;
        logic [31:0] setv, clrv;
        if (!rst_n) begin
            m_pre = 0; m_timer = '0; m_alarm = '0; m_stat = '0; m_en = '0;
            m_r = '0; m_p = '0;
        end else begin
            tk   = (m_pre == P - 1) && !(wr && addr == 8'h10);
            setv = '0;
            if (tk && (m_timer + 32'd1) == m_alarm) setv[0] = 1'b1;
            if (m_r[1] && !m_r[2]) setv[17] = 1'b1;
            if (m_p[1] && !m_p[2]) setv[11] = 1'b1;
            clrv = (wr && addr == 8'h38) ? wdata : '0;
            m_stat = (m_stat & ~clrv) | setv;
            if (wr && addr == 8'h14) m_alarm = wdata;
            if (wr && addr == 8'h3C) m_en = wdata;
            if (wr && addr == 8'h10) begin
                m_timer = wdata; m_pre = 0;
            end else if (m_pre == P - 1) begin
                m_pre = 0; m_timer = m_timer + 32'd1;
            end else begin
                m_pre = m_pre + 1;
            end
            m_r = {m_r[1:0], btn_r};
            m_p = {m_p[1:0], btn_p};
        end
    end

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h10:   return m_timer;
            8'h14:   return m_alarm;
            8'h38:   return m_stat;
            8'h3C:   return m_en;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model.
    always @(posedge clk) begin
        #5;
        if (!done) begin
            chk({tag, " rdata"}, rdata, model_read(addr));
            chk("R9 irq", {31'd0, irq}, {31'd0, |(m_stat & m_en)});
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
            finish_run();
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        addr = a;
        #1 v = rdata;
    endtask

    logic [31:0] v, t0;

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1: reset values
        tag = "R1";
        rd(8'h10, v); chk("R1 timer", v, 32'h0);
        rd(8'h14, v); chk("R1 alarm", v, 32'h0);
        rd(8'h38, v); chk("R1 status", v, 32'h0);
        rd(8'h3C, v); chk("R1 enable", v, 32'h0);
        chk("R1 irq", {31'd0, irq}, 32'h0);

        // R2: one step per P clocks
        tag = "R2";
        idle(3);
        rd(8'h10, t0); idle(P); rd(8'h10, v);
        chk("R2 step", v, t0 + 32'd1);

        // R3: load and prescaler restart
        tag = "R3";
        write(8'h10, 32'd100);
        rd(8'h10, v); chk("R3 load", v, 32'd100);
        idle(P - 1); rd(8'h10, v); chk("R3 hold", v, 32'd100);
        idle(1); rd(8'h10, v); chk("R3 first step", v, 32'd101);

        // R4: step onto alarm, once only, clear while equal
        tag = "R4";
        write(8'h3C, 32'hFFFF_FFFF);
        write(8'h14, 32'h200);
        write(8'h10, 32'h1FF);
        idle(P); rd(8'h38, v); chk("R4 alarm set", v, 32'h1);
        chk("R9 irq on alarm", {31'd0, irq}, 32'h1);
        tag = "R7";
        write(8'h38, 32'h0);
        rd(8'h38, v); chk("R7 zero write keeps", v, 32'h1);
        write(8'h38, 32'h1);
        rd(8'h38, v); chk("R7 clear", v, 32'h0);
        tag = "R4";
        idle(2 * P); rd(8'h38, v); chk("R4 no refire", v, 32'h0);
        write(8'h14, 32'h300);
        write(8'h10, 32'h300);
        idle(2 * P); rd(8'h38, v); chk("R4 load equal no set", v, 32'h0);

        // R2/R4: wrap onto alarm 0
        tag = "R2";
        write(8'h14, 32'h0);
        write(8'h10, 32'hFFFF_FFFF);
        idle(P); rd(8'h10, v); chk("R2 wrap", v, 32'h0);
        rd(8'h38, v); chk("R4 wrap alarm", v, 32'h1);
        write(8'h38, 32'hFFFF_FFFF);

        // R5: reset button, once per press
        tag = "R5";
        @(negedge clk); btn_r = 1'b1;
        idle(2); rd(8'h38, v); chk("R5 not yet", v, 32'h0);
        idle(1); rd(8'h38, v); chk("R5 set", v, 32'h20000);
        write(8'h38, 32'h20000);
        idle(10); rd(8'h38, v); chk("R5 held no reset", v, 32'h0);
        btn_r = 1'b0; idle(5);
        btn_r = 1'b1; idle(5); rd(8'h38, v); chk("R5 second press", v, 32'h20000);
        btn_r = 1'b0;
        write(8'h38, 32'hFFFF_FFFF);

        // R6: power button
        tag = "R6";
        @(negedge clk); btn_p = 1'b1;
        idle(3); rd(8'h38, v); chk("R6 set", v, 32'h800);
        write(8'h38, 32'h800);
        idle(8); rd(8'h38, v); chk("R6 held no reset", v, 32'h0);
        btn_p = 1'b0; idle(5);

        // R9: masking
        tag = "R9";
        write(8'h3C, 32'h800);
        write(8'h14, 32'hFFFF_0000);
        @(negedge clk); btn_r = 1'b1;
        idle(4); rd(8'h38, v); chk("R9 status unmasked", v, 32'h20000);
        chk("R9 masked irq low", {31'd0, irq}, 32'h0);
        @(negedge clk); btn_p = 1'b1;
        idle(4); chk("R9 enabled irq high", {31'd0, irq}, 32'h1);
        btn_r = 1'b0; btn_p = 1'b0;
        write(8'h38, 32'hFFFF_FFFF);
        idle(4);

        // R8: set and clear in the same clock
        tag = "R8";
        @(negedge clk); btn_p = 1'b1;
        @(posedge clk); @(posedge clk);
        write(8'h38, 32'h800);
        rd(8'h38, v); chk("R8 set wins", v, 32'h800);
        btn_p = 1'b0;

        // R10: unmapped offsets and unused bits
        tag = "R10";
        write(8'h40, 32'hFFFF_FFFF);
        rd(8'h40, v); chk("R10 unmapped", v, 32'h0);
        rd(8'h34, v); chk("R10 unmapped 2", v, 32'h0);
        rd(8'h38, v); chk("R10 status only source bits", v & ~32'h20801, 32'h0);

        idle(4);
        finish_run();
    end

endmodule